// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block keeps a 24-bit sticky status word and a 24-bit enable mask, and from the two it drives one interrupt pin. Event pulses from the measurement logic set status bits, and they set them whether or not the bits are enabled in the mask. The host clears bits by writing a word in which each 1 clears the matching bit and each 0 leaves it alone. Software can therefore write back the value it read and lose no event that arrived in between.

Two bits follow their own rules. Bit 0 is an active-low flag for an illegal command. A status write cannot restore it; only a port-initialization strobe does. Bit 5 is a watchdog flag. It sets when the energy result has not been read for a programmable number of cycles. A status write can clear it only after an energy read has occurred since the flag was set. A 2-bit mode input selects how the pin is driven: as a low level, a high level, a falling pulse or a rising pulse.

Top module: `stat_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0x000001, the mask becomes 0x000000 and `rd_data` becomes 0. `irq_pin` becomes 1 in modes 00 and 10 and 0 in modes 01 and 11.
- R2: A write with `reg_sel`=0 clears each live status bit (other than bits 0 and 5) that is 1 in `reg_wdata`. Bits written as 0 keep their value.
- R3: A pulse on `evt_pulse[i]` sets live status bit i (other than bits 0 and 5) regardless of the mask. When a clearing write hits the same bit in the same cycle, the event wins and the bit stays 1.
- R4: Status bit 0 goes to 0 when `evt_pulse[0]` pulses and returns to 1 only on `port_init`. Status writes do not affect it. When both strobes arrive in the same cycle, `port_init` wins.
- R5: The live bits are 23, 22, 21, 19, 17, 16, 15, 14, 13, 12, 11, 5, 4, 3, 2 and 0 (live mask 0xEBF83D). All other bits of the status word and of the mask always read 0. Writes and events aimed at them are ignored, and `evt_pulse[5]` is ignored as well.
- R6: The interrupt condition is true when some live status bit is active and its mask bit is 1. Bit 0 counts as active when it is 0; every other bit counts as active when it is 1. A write with `reg_sel`=1 loads the mask.
- R7: In mode 00, `irq_pin` equals the inverse of the interrupt condition. In mode 01, it equals the condition. In both level modes the pin follows the condition one clock later.
- R8: In mode 11, `irq_pin` rests at 0 and is 1 for one clock, one clock after each rise of the condition. In mode 10 it rests at 1 and gives a one-clock 0 pulse at the same time.
- R9: Status bit 5 sets at the `WDOG_CYCLES`-th consecutive clock edge without `energy_rd`. The default of 20,480,000 is 5 s at 4.096 MHz. Each `energy_rd` restarts the count, and the bit sets again only after a further full period.
- R10: A status write of 1 to bit 5 clears it only if `energy_rd` has pulsed since the bit last became set. Otherwise the bit stays 1.
- R11: `rd_data` is registered. One clock after an edge, it holds the status word (`rd_sel`=0) or the mask (`rd_sel`=1) as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (divided clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 status (clear by ones), 1 mask |
| reg_wdata | input | 24 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 mask |
| rd_data | output | 24 | Registered read data |
| evt_pulse | input | 24 | Per-bit event pulses; bit 0 means illegal command |
| energy_rd | input | 1 | Pulse when the energy result is read |
| port_init | input | 1 | Pulse when the port initialization completes |
| irq_mode | input | 2 | Pin mode: 00 low level, 01 high level, 10 falling pulse, 11 rising pulse |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The bench targets the following corner cases:
- An event and a clearing write to the same bit in the same cycle. A design that gives the write priority would lose the event.
- A write of all ones to the status word. A design that treats bit 0 like the others would wrongly restore the illegal-command flag.
- A clear of the watchdog flag attempted with no energy read and then again after a read. A design missing the read interlock would clear it on the first write.
- An interrupt condition held high in the edge modes. A design with a level in place of a pulse would hold the pin active.
- The exact edge on which the watchdog expires after a read. An off-by-one counter would shift the flag by a cycle.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int STAT_W = 24;

  localparam int B_INV   = 0;
  localparam int B_LOWSUP = 2;
  localparam int B_IOSC  = 3;
  localparam int B_VOSC  = 4;
  localparam int B_WDT   = 5;
  localparam int B_PACC  = 11;
  localparam int B_EOR   = 12;
  localparam int B_VRMS  = 13;
  localparam int B_IRMS  = 14;
  localparam int B_PWR   = 15;
  localparam int B_VOR   = 16;
  localparam int B_IOR   = 17;
  localparam int B_MATH  = 19;
  localparam int B_DIR   = 21;
  localparam int B_PULSE = 22;
  localparam int B_DRDY  = 23;

  localparam logic [STAT_W-1:0] ONE_W = STAT_W'(1);

  localparam logic [STAT_W-1:0] LIVE_MASK =
    (ONE_W << B_INV)  | (ONE_W << B_LOWSUP) | (ONE_W << B_IOSC) | (ONE_W << B_VOSC) |
    (ONE_W << B_WDT)  | (ONE_W << B_PACC)   | (ONE_W << B_EOR)  | (ONE_W << B_VRMS) |
    (ONE_W << B_IRMS) | (ONE_W << B_PWR)    | (ONE_W << B_VOR)  | (ONE_W << B_IOR)  |
    (ONE_W << B_MATH) | (ONE_W << B_DIR)    | (ONE_W << B_PULSE)| (ONE_W << B_DRDY);

  localparam logic [STAT_W-1:0] STAT_RST = ONE_W << B_INV;

  typedef enum logic [1:0] {
    PIN_LVL_LO = 2'b00,
    PIN_LVL_HI = 2'b01,
    PIN_FALL   = 2'b10,
    PIN_RISE   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/sic_watchdog.sv
module sic_watchdog #(
  parameter int LIMIT = 20480000
) (
  input  logic clk,
  input  logic rst,
  input  logic energy_rd,
  output logic fire,
  output logic armed
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          arm_q;

  assign fire  = !energy_rd && (cnt_q == LAST);
  assign armed = arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (energy_rd)        cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      if (fire)             arm_q <= 1'b0;
      else if (energy_rd)   arm_q <= 1'b1;
    end
  end

  a_r9_read_restarts: assert property (@(posedge clk) disable iff (rst)
    energy_rd |=> !fire);
  a_r10_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed);
endmodule

// File: rtl/sic_status_bank.sv
module sic_status_bank
  import sic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] wclr,
  input  logic [STAT_W-1:0] evt,
  input  logic              port_init,
  input  logic              wdt_fire,
  input  logic              wdt_clr_ok,
  output logic [STAT_W-1:0] stat_q
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == B_INV) begin : g_inv
      logic b_q;
      logic unused_inv;
      assign unused_inv = wclr[i];
      always_ff @(posedge clk) begin
        if (rst)            b_q <= 1'b1;
        else if (port_init) b_q <= 1'b1;
        else if (evt[i])    b_q <= 1'b0;
      end
      assign stat_q[i] = b_q;

      a_r4_inv_hold: assert property (@(posedge clk) disable iff (rst)
        (!port_init && !evt[i]) |=> $stable(b_q));
      a_r4_init_restore: assert property (@(posedge clk) disable iff (rst)
        port_init |=> b_q);
    end else if (i == B_WDT) begin : g_wdt
      logic b_q;
      logic unused_wdt;
      assign unused_wdt = evt[i];
      always_ff @(posedge clk) begin
        if (rst)                           b_q <= 1'b0;
        else if (wdt_fire)                 b_q <= 1'b1;
        else if (wclr[i] && wdt_clr_ok)    b_q <= 1'b0;
      end
      assign stat_q[i] = b_q;

      a_r9_fire_sets: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |=> b_q);
      a_r10_no_clear_unarmed: assert property (@(posedge clk) disable iff (rst)
        (b_q && !wdt_clr_ok) |=> b_q);
    end else if (LIVE_MASK[i]) begin : g_live
      logic b_q;
      always_ff @(posedge clk) begin
        if (rst)          b_q <= 1'b0;
        else if (evt[i])  b_q <= 1'b1;
        else if (wclr[i]) b_q <= 1'b0;
      end
      assign stat_q[i] = b_q;

      a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
        (wclr[i] && !evt[i]) |=> !b_q);
      a_r3_evt_sets: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> b_q);
    end else begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = evt[i] ^ wclr[i];
      assign stat_q[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/sic_pin_drv.sv
module sic_pin_drv
  import sic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cond,
  output logic       pin
);
  logic cond_q;
  logic pin_q;
  logic rise;

  assign rise = cond && !cond_q;
  assign pin  = pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pin_q  <= (mode == PIN_LVL_LO) || (mode == PIN_FALL);
    end else begin
      cond_q <= cond;
      case (pin_mode_e'(mode))
        PIN_LVL_LO: pin_q <= !cond;
        PIN_LVL_HI: pin_q <= cond;
        PIN_FALL:   pin_q <= !rise;
        default:    pin_q <= rise;
      endcase
    end
  end

  a_r7_level_hi: assert property (@(posedge clk) disable iff (rst)
    (mode == PIN_LVL_HI) |=> (pin == $past(cond)));
  a_r7_level_lo: assert property (@(posedge clk) disable iff (rst)
    (mode == PIN_LVL_LO) |=> (pin == !$past(cond)));
  a_r8_rise_once: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == PIN_RISE && mode == PIN_RISE && pin) |=> !pin);
  a_r8_fall_once: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == PIN_FALL && mode == PIN_FALL && !pin) |=> pin);
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import sic_pkg::*;
#(
  parameter int WDOG_CYCLES = 20480000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic              rd_sel,
  output logic [STAT_W-1:0] rd_data,
  input  logic [STAT_W-1:0] evt_pulse,
  input  logic              energy_rd,
  input  logic              port_init,
  input  logic [1:0]        irq_mode,
  output logic              irq_pin
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] wclr;
  logic [STAT_W-1:0] active;
  logic [STAT_W-1:0] rd_q;
  logic              wdt_fire;
  logic              wdt_armed;
  logic              cond;

  assign wclr   = (reg_wr && !reg_sel) ? reg_wdata : '0;
  assign active = (stat_q ^ STAT_RST) & mask_q;
  assign cond   = |active;

  sic_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .energy_rd (energy_rd),
    .fire      (wdt_fire),
    .armed     (wdt_armed)
  );

  sic_status_bank u_stat (
    .clk        (clk),
    .rst        (rst),
    .wclr       (wclr),
    .evt        (evt_pulse),
    .port_init  (port_init),
    .wdt_fire   (wdt_fire),
    .wdt_clr_ok (wdt_armed),
    .stat_q     (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rd_q   <= '0;
    end else begin
      if (reg_wr && reg_sel) mask_q <= reg_wdata & LIVE_MASK;
      rd_q <= rd_sel ? mask_q : stat_q;
    end
  end

  assign rd_data = rd_q;

  sic_pin_drv u_pin (
    .clk  (clk),
    .rst  (rst),
    .mode (irq_mode),
    .cond (cond),
    .pin  (irq_pin)
  );

  a_r5_mask_live: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> ((mask_q & ~LIVE_MASK) == '0));
  a_r11_read_path: assert property (@(posedge clk) disable iff (rst)
    rd_sel |=> (rd_data == $past(mask_q)));
endmodule

// File: tb/stat_irq_ctrl_tb_top.sv
module stat_irq_ctrl_tb_top;
  localparam int LIM = 40;
  localparam logic [23:0] LIVE = 24'hEBF83D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0, rd_sel = 1'b0;
  logic [23:0] reg_wdata = '0, evt_pulse = '0;
  logic        energy_rd = 1'b0, port_init = 1'b0;
  logic [1:0]  irq_mode = 2'b00;
  logic [23:0] rd_data;
  logic        irq_pin;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    started = 0;

  always #10 clk = ~clk;

  stat_irq_ctrl #(.WDOG_CYCLES(LIM)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_pulse(evt_pulse), .energy_rd(energy_rd),
    .port_init(port_init), .irq_mode(irq_mode), .irq_pin(irq_pin)
  );

  // behavioural reference model
  logic [23:0] m_stat, m_mask, m_rd;
  logic        m_pin, m_cq, m_arm;
  int          m_cnt;

  always @(posedge clk) begin
    logic [23:0] ns, nm;
    logic cond, fire, np;
    if (rst) begin
      m_stat = 24'h000001; m_mask = '0; m_rd = '0; m_cq = 0; m_arm = 0; m_cnt = 0;
      m_pin = (irq_mode == 2'b00) || (irq_mode == 2'b10);
    end else begin
      cond = |(((m_stat ^ 24'h1) & LIVE) & m_mask);
      case (irq_mode)
        2'b00: np = !cond;
        2'b01: np = cond;
        2'b10: np = !(cond && !m_cq);
        default: np = cond && !m_cq;
      endcase
      fire = !energy_rd && (m_cnt == LIM - 1);
      ns = m_stat; nm = m_mask;
      if (reg_wr && !reg_sel) ns = ns & ~(reg_wdata & LIVE & ~24'h21);
      ns = ns | (evt_pulse & LIVE & ~24'h21);
      if (fire) ns[5] = 1'b1;
      else if (reg_wr && !reg_sel && reg_wdata[5] && m_arm) ns[5] = 1'b0;
      if (port_init) ns[0] = 1'b1;
      else if (evt_pulse[0]) ns[0] = 1'b0;
      if (reg_wr && reg_sel) nm = reg_wdata & LIVE;
      m_rd = rd_sel ? m_mask : m_stat;
      m_pin = np; m_cq = cond;
      if (fire) m_arm = 0; else if (energy_rd) m_arm = 1;
      if (energy_rd) m_cnt = 0; else if (m_cnt < LIM) m_cnt++;
      m_stat = ns; m_mask = nm;
    end
    started = 1;
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      chk({cur_req, " rd_data"}, rd_data, m_rd);
      chk({cur_req, " irq_pin"}, {23'd0, irq_pin}, {23'd0, m_pin});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [23:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    cyc(1);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic ev(input logic [23:0] e);
    evt_pulse = e; cyc(1); evt_pulse = '0;
  endtask

  task automatic rd(input logic sel, output logic [23:0] v);
    rd_sel = sel; cyc(1); v = rd_data; rd_sel = 0;
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    logic [23:0] v;
    cyc(3); rst = 0;
    // R1 reset state
    cur_req = "R1";
    chk("R1 pin", {23'd0, irq_pin}, 24'd1);
    rd(0, v); chk("R1 status", v, 24'h000001);
    rd(1, v); chk("R1 mask", v, 24'h000000);
    // R3/R5 events set with mask 0, reserved and bit 5 ignored
    cur_req = "R3";
    ev(24'hFFFFFF);
    rd(0, v); chk("R3 R5 events", v & ~24'h20, 24'hEBF81C);
    chk("R6 masked pin idle", {23'd0, irq_pin}, 24'd1);
    // R2 write one to clear
    cur_req = "R2";
    wr(0, 24'h00F000);
    rd(0, v); chk("R2 partial clear", v & ~24'h20, 24'hEB081C);
    wr(0, 24'h000000);
    rd(0, v); chk("R2 zero write keeps", v & ~24'h20, 24'hEB081C);
    // R3 event wins over same-cycle clear
    cur_req = "R3";
    reg_wr = 1; reg_sel = 0; reg_wdata = 24'h800000; evt_pulse = 24'h800000;
    cyc(1); reg_wr = 0; reg_wdata = '0; evt_pulse = '0;
    rd(0, v); chk("R3 collision", v & 24'h800000, 24'h800000);
    // R4 invalid flag
    cur_req = "R4";
    wr(0, 24'hFFFFFF);
    rd(0, v); chk("R4 write ignores bit0", v & ~24'h20, 24'h000000);
    port_init = 1; evt_pulse = 24'h000001; cyc(1); port_init = 0; evt_pulse = '0;
    rd(0, v); chk("R4 init restores", v & 24'h1, 24'h000001);
    // R5 mask reserved bits
    cur_req = "R5";
    wr(1, 24'hFFFFFF);
    rd(1, v); chk("R5 R11 mask readback", v, 24'hEBF83D);
    // R6/R7 level modes
    cur_req = "R7";
    wr(1, 24'h000008);
    irq_mode = 2'b01; cyc(2);
    chk("R7 hi idle", {23'd0, irq_pin}, 24'd0);
    ev(24'h000008); cyc(1);
    chk("R6 R7 hi active", {23'd0, irq_pin}, 24'd1);
    irq_mode = 2'b00; cyc(2);
    chk("R7 lo active", {23'd0, irq_pin}, 24'd0);
    wr(0, 24'h000008); cyc(1);
    chk("R2 R7 clear deasserts", {23'd0, irq_pin}, 24'd1);
    cur_req = "R6";
    wr(1, 24'h000001); cyc(2);
    chk("R6 bit0 inactive", {23'd0, irq_pin}, 24'd1);
    ev(24'h000001); cyc(1);
    chk("R6 bit0 active low", {23'd0, irq_pin}, 24'd0);
    port_init = 1; cyc(1); port_init = 0;
    // R8 edge modes
    cur_req = "R8";
    wr(1, 24'h000010); irq_mode = 2'b11; cyc(2);
    ev(24'h000010);
    chk("R8 rise not yet", {23'd0, irq_pin}, 24'd0);
    cyc(1); chk("R8 rise pulse", {23'd0, irq_pin}, 24'd1);
    cyc(1); chk("R8 rise ends", {23'd0, irq_pin}, 24'd0);
    wr(0, 24'h000010); irq_mode = 2'b10; cyc(2);
    ev(24'h000010); cyc(1);
    chk("R8 fall pulse", {23'd0, irq_pin}, 24'd0);
    cyc(1); chk("R8 fall ends", {23'd0, irq_pin}, 24'd1);
    wr(0, 24'h000010); wr(1, 24'h000000);
    // R9/R10 watchdog
    cur_req = "R9";
    cyc(LIM + 2);
    rd(0, v); chk("R9 expired", v & 24'h20, 24'h20);
    cur_req = "R10";
    wr(0, 24'h000020);
    rd(0, v); chk("R10 no read no clear", v & 24'h20, 24'h20);
    energy_rd = 1; cyc(1); energy_rd = 0;
    wr(0, 24'h000020);
    cur_req = "R9";
    cyc(LIM - 4);
    rd(0, v); chk("R10 R9 cleared before limit", v & 24'h20, 24'h00);
    cyc(2);
    rd(0, v); chk("R9 sets at limit", v & 24'h20, 24'h20);
    cur_req = "R11";
    rd(1, v); chk("R11 mask read", v, 24'h000000);
    cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule